// File: doc/BRIEF.md
# Code Memory Verify Sequencer

This block walks a target device's program memory, and after that its small identification region, and compares every 16-bit word against an expected image. The expected image sits in a host-side buffer that the block reads one word at a time. The device is reached through a serial command engine. That engine accepts two kinds of request: load the device's 22-bit table pointer, or read one byte at the pointer and then advance the pointer by one.

A run begins with a start pulse. The sequencer loads the pointer with zero. For each word it issues two byte reads, low byte first and high byte second, fetches the matching expected word, and compares the two. The device pointer wraps at the end of implemented code memory. For that reason the sequencer never counts on post-increment to reach the identification region: once the last code word matches, it loads the region's base address explicitly. The first word that differs ends the run. The block then holds the word's byte address, the value read back and the value expected, and raises an error flag together with done.

Top module: `code_verify_seq`

## Requirements
- R1: While reset is held, busy, done and error are low, and neither cmdValid nor bufReq is asserted.
- R2: A start pulse while idle or finished makes the first command a pointer load (cmdOp = 0) with cmdPtr = 0. cmdOp = 1 means a byte read with post-increment.
- R3: Each word is checked with exactly two byte reads. The first returned byte is taken as bits 7:0 and the second as bits 15:8. One buffer fetch follows them before the next command.
- R4: The buffer index for code word n is n. For identification word j it is CODE_WORDS + j.
- R5: After the last code word matches, a pointer load with ID_BASE (default 200000h) is issued before any identification-region read.
- R6: When every word matches, the run ends with done high, error low and busy low, after exactly 2 + 2*(CODE_WORDS + ID_WORDS) commands.
- R7: On the first mismatching word, no further command or buffer request is issued. done and error go high. failAddr holds the word's low-byte address (2n for code, ID_BASE + 2j for identification), failRead holds the word read back, and failExpect holds the buffer word.
- R8: A start pulse while a run is in progress has no effect on the command sequence or on the result.
- R9: A start pulse after a finished run clears done and error, and the next cycle shows busy high.
- R10: Any response latency is tolerated. A pending command holds cmdValid, cmdOp and cmdPtr stable until cmdDone, and a pending buffer request holds bufReq and bufIndex until bufAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a verify run (single-cycle pulse) |
| cmdValid | output | 1 | Command request to the serial command engine |
| cmdOp | output | 1 | 0 = load pointer, 1 = byte read with post-increment |
| cmdPtr | output | PTR_W | Pointer value for a load command |
| cmdDone | input | 1 | Command completed (single-cycle pulse) |
| cmdData | input | 8 | Byte returned by a read, valid with cmdDone |
| bufReq | output | 1 | Expected-word request to the host buffer |
| bufIndex | output | IdxW | Word index into the host buffer |
| bufAck | input | 1 | Buffer word valid (single-cycle pulse) |
| bufWord | input | 16 | Expected word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until the next start |
| error | output | 1 | Run finished on a mismatch |
| failAddr | output | PTR_W | Byte address of the failing word |
| failRead | output | 16 | Word read from the device |
| failExpect | output | 16 | Word expected from the buffer |

## Verification
The device model holds a clean copy of the image, which gives a full pass, and the bench then corrupts single bytes in chosen places. A corrupted low byte and a corrupted high byte show whether the two reads are assembled in the right order. Corruptions in word zero and in the last code word test the edges of the code region. Corruptions in the identification region show whether the pointer was reloaded explicitly: the modelled device wraps to zero at the end of code memory, so post-increment alone would read code bytes. Command latencies from zero to three cycles, and a stray start pulse in the middle of a run, test the hold rules and show that the start pulse is ignored while busy.

// File: rtl/verify_pkg.sv
package verify_pkg;

  typedef struct packed {
    logic clrAll;
    logic ldLo;
    logic ldHi;
    logic ldExp;
    logic nextWord;
    logic enterId;
    logic latchFail;
  } seqStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_RDLO,
    S_RDHI,
    S_FETCH,
    S_CMP,
    S_FIN
  } seqState_t;

  localparam logic OP_LOAD = 1'b0;
  localparam logic OP_READ = 1'b1;

endpackage

// File: rtl/verify_ctrl.sv
module verify_ctrl
  import verify_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cmdDone,
  input  logic       bufAck,
  input  logic       mismatch,
  input  logic       lastWord,
  input  logic       inId,
  output logic       cmdValid,
  output logic       cmdOp,
  output logic       bufReq,
  output logic       busy,
  output logic       done,
  output seqStrobe_t strobe
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE, S_FIN: begin
        if (start) begin
          strobe.clrAll = 1'b1;
          nextState     = S_LOAD;
        end
      end
      S_LOAD: if (cmdDone) nextState = S_RDLO;
      S_RDLO: begin
        if (cmdDone) begin
          strobe.ldLo = 1'b1;
          nextState   = S_RDHI;
        end
      end
      S_RDHI: begin
        if (cmdDone) begin
          strobe.ldHi = 1'b1;
          nextState   = S_FETCH;
        end
      end
      S_FETCH: begin
        if (bufAck) begin
          strobe.ldExp = 1'b1;
          nextState    = S_CMP;
        end
      end
      S_CMP: begin
        if (mismatch) begin
          strobe.latchFail = 1'b1;
          nextState        = S_FIN;
        end else if (lastWord) begin
          if (inId) begin
            nextState = S_FIN;
          end else begin
            strobe.enterId = 1'b1;
            nextState      = S_LOAD;
          end
        end else begin
          strobe.nextWord = 1'b1;
          nextState       = S_RDLO;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign cmdValid = (state == S_LOAD) || (state == S_RDLO) || (state == S_RDHI);
  assign cmdOp    = (state == S_LOAD) ? OP_LOAD : OP_READ;
  assign bufReq   = (state == S_FETCH);
  assign busy     = (state != S_IDLE) && (state != S_FIN);
  assign done     = (state == S_FIN);

endmodule

// File: rtl/verify_dp.sv
module verify_dp
  import verify_pkg::*;
#(
  parameter int              CODE_WORDS = 64,
  parameter int              ID_WORDS   = 4,
  parameter int              PTR_W      = 22,
  parameter logic [PTR_W-1:0] ID_BASE   = 22'h200000,
  parameter int              IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [7:0]       cmdData,
  input  logic [15:0]      bufWord,
  output logic             mismatch,
  output logic             lastWord,
  output logic             inId,
  output logic [PTR_W-1:0] cmdPtr,
  output logic [IDX_W-1:0] bufIndex,
  output logic             error,
  output logic [PTR_W-1:0] failAddr,
  output logic [15:0]      failRead,
  output logic [15:0]      failExpect
);

  localparam int MaxWords = (CODE_WORDS > ID_WORDS) ? CODE_WORDS : ID_WORDS;
  localparam int WordW    = (MaxWords > 1) ? $clog2(MaxWords) : 1;

  logic [7:0]       loByte, hiByte;
  logic [15:0]      expWord;
  logic [WordW-1:0] wordIdx;
  logic [PTR_W-1:0] regionBase, wordAddr;

  assign regionBase = inId ? ID_BASE : '0;
  assign wordAddr   = regionBase + PTR_W'({wordIdx, 1'b0});
  assign cmdPtr     = regionBase;
  assign bufIndex   = inId ? (IDX_W'(CODE_WORDS) + IDX_W'(wordIdx)) : IDX_W'(wordIdx);
  assign mismatch   = {hiByte, loByte} != expWord;
  assign lastWord   = inId ? (wordIdx == WordW'(ID_WORDS - 1))
                           : (wordIdx == WordW'(CODE_WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte  <= '0;
      hiByte  <= '0;
      expWord <= '0;
    end else begin
      if (strobe.ldLo)  loByte  <= cmdData;
      if (strobe.ldHi)  hiByte  <= cmdData;
      if (strobe.ldExp) expWord <= bufWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      inId    <= 1'b0;
    end else if (strobe.clrAll) begin
      wordIdx <= '0;
      inId    <= 1'b0;
    end else if (strobe.enterId) begin
      wordIdx <= '0;
      inId    <= 1'b1;
    end else if (strobe.nextWord) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      error      <= 1'b0;
      failAddr   <= '0;
      failRead   <= '0;
      failExpect <= '0;
    end else if (strobe.clrAll) begin
      error      <= 1'b0;
      failAddr   <= '0;
      failRead   <= '0;
      failExpect <= '0;
    end else if (strobe.latchFail) begin
      error      <= 1'b1;
      failAddr   <= wordAddr;
      failRead   <= {hiByte, loByte};
      failExpect <= expWord;
    end
  end

endmodule

// File: rtl/code_verify_seq.sv
module code_verify_seq
  import verify_pkg::*;
#(
  parameter int               CODE_WORDS = 64,
  parameter int               ID_WORDS   = 4,
  parameter int               PTR_W      = 22,
  parameter logic [PTR_W-1:0] ID_BASE    = 22'h200000,
  localparam int              IdxW       = $clog2(CODE_WORDS + ID_WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             cmdValid,
  output logic             cmdOp,
  output logic [PTR_W-1:0] cmdPtr,
  input  logic             cmdDone,
  input  logic [7:0]       cmdData,
  output logic             bufReq,
  output logic [IdxW-1:0]  bufIndex,
  input  logic             bufAck,
  input  logic [15:0]      bufWord,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [PTR_W-1:0] failAddr,
  output logic [15:0]      failRead,
  output logic [15:0]      failExpect
);

  seqStrobe_t strobe;
  logic       mismatch, lastWord, inId;

  verify_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cmdDone  (cmdDone),
    .bufAck   (bufAck),
    .mismatch (mismatch),
    .lastWord (lastWord),
    .inId     (inId),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .bufReq   (bufReq),
    .busy     (busy),
    .done     (done),
    .strobe   (strobe)
  );

  verify_dp #(
    .CODE_WORDS (CODE_WORDS),
    .ID_WORDS   (ID_WORDS),
    .PTR_W      (PTR_W),
    .ID_BASE    (ID_BASE),
    .IDX_W      (IdxW)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmdData    (cmdData),
    .bufWord    (bufWord),
    .mismatch   (mismatch),
    .lastWord   (lastWord),
    .inId       (inId),
    .cmdPtr     (cmdPtr),
    .bufIndex   (bufIndex),
    .error      (error),
    .failAddr   (failAddr),
    .failRead   (failRead),
    .failExpect (failExpect)
  );

endmodule

// File: rtl/verify_chk.sv
module verify_chk #(
  parameter int PTR_W = 22,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdOp,
  input logic [PTR_W-1:0] cmdPtr,
  input logic             cmdDone,
  input logic             bufReq,
  input logic [IDX_W-1:0] bufIndex,
  input logic             bufAck,
  input logic             busy,
  input logic             done,
  input logic             error
);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdDone |=> cmdValid && $stable(cmdOp) && $stable(cmdPtr)); // R10

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bufReq && !bufAck |=> bufReq && $stable(bufIndex)); // R10

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> cmdValid && !cmdOp && (cmdPtr == '0)); // R2

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && bufReq)); // R3

  AST_QUIET_END: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid && !bufReq); // R7

  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done && !busy); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6

endmodule

bind code_verify_seq verify_chk #(.PTR_W(PTR_W), .IDX_W(IdxW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdPtr   (cmdPtr),
  .cmdDone  (cmdDone),
  .bufReq   (bufReq),
  .bufIndex (bufIndex),
  .bufAck   (bufAck),
  .busy     (busy),
  .done     (done),
  .error    (error)
);

// File: tb/sim_code_verify_seq.sv
module sim_code_verify_seq;

  localparam int          CW     = 16;
  localparam int          IW     = 4;
  localparam int          PW     = 22;
  localparam logic [21:0] IDBASE = 22'h200000;
  localparam int          XW     = $clog2(CW + IW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          cmdValid, cmdOp, bufReq, busy, done, error;
  logic [PW-1:0] cmdPtr, failAddr;
  logic          cmdDone = 1'b0;
  logic [7:0]    cmdData = 8'h00;
  logic [XW-1:0] bufIndex;
  logic          bufAck = 1'b0;
  logic [15:0]   bufWord = 16'h0000;
  logic [15:0]   failRead, failExpect;

  code_verify_seq #(.CODE_WORDS(CW), .ID_WORDS(IW), .PTR_W(PW), .ID_BASE(IDBASE)) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPtr(cmdPtr), .cmdDone(cmdDone), .cmdData(cmdData),
    .bufReq(bufReq), .bufIndex(bufIndex), .bufAck(bufAck), .bufWord(bufWord),
    .busy(busy), .done(done), .error(error),
    .failAddr(failAddr), .failRead(failRead), .failExpect(failExpect)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0]  devCode [2*CW];
  logic [7:0]  devId   [2*IW];
  logic [15:0] expImg  [CW+IW];
  int devPtr = 0;
  int cmdLat = 0;
  int latCnt = 0;
  int qOp[$], qPtr[$], qIdx[$];
  bit expFail;
  int expAddr;
  logic [15:0] expRd, expEx;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] devRead();
    logic [7:0] d;
    if (devPtr < 2*CW) begin
      d = devCode[devPtr];
      devPtr = (devPtr + 1) % (2*CW);
    end else if (devPtr >= int'(IDBASE) && devPtr < int'(IDBASE) + 2*IW) begin
      d = devId[devPtr - int'(IDBASE)];
      devPtr++;
    end else begin
      d = 8'hFF;
      devPtr = (devPtr + 1) & 32'h3FFFFF;
    end
    return d;
  endfunction

  task automatic serveCmd();
    int eop, eptr;
    if (qOp.size() == 0) begin
      check(1'b0, "R7", "command after end of expected sequence", cmdOp, 0);
    end else begin
      eop  = qOp.pop_front();
      eptr = qPtr.pop_front();
      check(int'(cmdOp) == eop, (eop == 0) ? "R2" : "R3", "command kind", cmdOp, eop);
      if (eptr >= 0)
        check(int'(cmdPtr) == eptr, (eptr == 0) ? "R2" : "R5", "pointer load value", cmdPtr, eptr);
    end
    if (cmdOp == 1'b0) devPtr = int'(cmdPtr);
    else               cmdData = devRead();
  endtask

  task automatic serveBuf();
    int eidx;
    if (qIdx.size() == 0) begin
      check(1'b0, "R7", "buffer request after end of expected sequence", bufIndex, 0);
    end else begin
      eidx = qIdx.pop_front();
      check(int'(bufIndex) == eidx, "R4", "buffer index", bufIndex, eidx);
    end
    bufWord = (int'(bufIndex) < CW + IW) ? expImg[bufIndex] : 16'hDEAD;
  endtask

  // Responder for the command engine and the host buffer, driven away from the active edge.
  always @(negedge clk) begin
    if (!rstN) begin
      cmdDone = 1'b0;
      bufAck  = 1'b0;
      latCnt  = 0;
    end else begin
      if (cmdDone) cmdDone = 1'b0;
      else if (cmdValid) begin
        if (latCnt >= cmdLat) begin
          latCnt = 0;
          serveCmd();
          cmdDone = 1'b1;
        end else latCnt++;
      end
      if (bufAck) bufAck = 1'b0;
      else if (bufReq) begin
        serveBuf();
        bufAck = 1'b1;
      end
    end
  end

  task automatic restore();
    for (int w = 0; w < CW + IW; w++) begin
      expImg[w] = (w < CW) ? (16'hA000 ^ 16'(w * 16'h1357)) : (16'h3C00 + 16'((w - CW) * 7));
    end
    for (int w = 0; w < CW; w++) begin
      devCode[2*w]   = expImg[w][7:0];
      devCode[2*w+1] = expImg[w][15:8];
    end
    for (int j = 0; j < IW; j++) begin
      devId[2*j]   = expImg[CW+j][7:0];
      devId[2*j+1] = expImg[CW+j][15:8];
    end
  endtask

  // Reference model: expected command and buffer traffic, stopped at the first differing word.
  task automatic prepare();
    logic [15:0] wd;
    qOp.delete(); qPtr.delete(); qIdx.delete();
    expFail = 1'b0;
    qOp.push_back(0); qPtr.push_back(0);
    for (int w = 0; w < CW; w++) begin
      qOp.push_back(1); qPtr.push_back(-1);
      qOp.push_back(1); qPtr.push_back(-1);
      qIdx.push_back(w);
      wd = {devCode[2*w+1], devCode[2*w]};
      if (wd != expImg[w]) begin
        expFail = 1'b1; expAddr = 2*w; expRd = wd; expEx = expImg[w];
        return;
      end
    end
    qOp.push_back(0); qPtr.push_back(int'(IDBASE));
    for (int j = 0; j < IW; j++) begin
      qOp.push_back(1); qPtr.push_back(-1);
      qOp.push_back(1); qPtr.push_back(-1);
      qIdx.push_back(CW + j);
      wd = {devId[2*j+1], devId[2*j]};
      if (wd != expImg[CW+j]) begin
        expFail = 1'b1; expAddr = int'(IDBASE) + 2*j; expRd = wd; expEx = expImg[CW+j];
        return;
      end
    end
  endtask

  task automatic runTest(input string name, input int lat, input bit midStart);
    int guard;
    prepare();
    cmdLat = lat;
    @(negedge clk); #1;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    check(busy && !done && !error, "R9", {name, " state right after start"},
          {busy, done, error}, 3'b100);
    if (midStart) begin
      repeat (10) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk); #1;
      guard++;
    end
    check(done && !busy, expFail ? "R7" : "R6", {name, " finished"}, {done, busy}, 2'b10);
    check(error == expFail, expFail ? "R7" : "R6", {name, " error flag"}, error, expFail);
    if (expFail) begin
      check(int'(failAddr) == expAddr, "R7", {name, " failAddr"}, failAddr, expAddr);
      check(failRead == expRd, "R7", {name, " failRead"}, failRead, expRd);
      check(failExpect == expEx, "R7", {name, " failExpect"}, failExpect, expEx);
    end
    repeat (6) @(negedge clk);
    #1;
    check(qOp.size() == 0 && qIdx.size() == 0, midStart ? "R8" : (expFail ? "R7" : "R6"),
          {name, " expected commands left unissued"}, qOp.size() + qIdx.size(), 0);
    check(!cmdValid && !bufReq && done, "R7", {name, " quiet after end"},
          {cmdValid, bufReq, done}, 3'b001);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    restore();
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !error, "R1", "status in reset", {busy, done, error}, 0);
    check(!cmdValid && !bufReq, "R1", "requests in reset", {cmdValid, bufReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    restore();
    runTest("clean lat0", 0, 1'b0);                        // R6
    runTest("clean lat3", 3, 1'b0);                        // R10
    restore(); devCode[2*5] ^= 8'h10;
    runTest("code w5 low byte", 1, 1'b0);                  // R7, R3
    restore(); devCode[1] ^= 8'h80;
    runTest("code w0 high byte", 2, 1'b0);                 // R7, R3
    restore(); devCode[2*CW-1] ^= 8'h01;
    runTest("last code word", 0, 1'b0);                    // R7
    restore(); devId[4] ^= 8'h22;
    runTest("id w2 low byte", 1, 1'b0);                    // R5, R7
    restore(); devId[2*IW-1] ^= 8'h40;
    runTest("id last high byte", 3, 1'b0);                 // R4, R7
    restore();
    runTest("restart after fail", 2, 1'b0);                // R9
    restore(); devCode[2*9+1] ^= 8'h05;
    runTest("start while busy", 1, 1'b1);                  // R8

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule